// File: doc/BRIEF.md
# SPDIF Biphase-Mark Subframe Receiver

This block takes the single serial line of an IEC 60958 audio stream and recovers it with a fast local clock, with no separate bit clock needed. The line carries data and clock together using biphase-mark coding. Every cell starts with a level change, and a logical one adds a second change in the middle of the cell. The receiver times the gap between changes on the line. It keeps a record of the shortest gap it has seen, which it takes to be one half-cell, and sorts each gap as one, two or three half-cells long. The bit timing this yields stays in step with the oversampling clock.

From these gap classes the receiver picks out the three preambles. A preamble fills the first four slots of a subframe and breaks the biphase rule on purpose. The receiver then gathers the 28 data slots that follow and hands over one 32-bit word per subframe. With each word it gives a flag for channel B and a flag that marks the first subframe of a 192-frame block. A subframe is only passed on once the receiver holds lock, which means two valid preambles in a row. A preamble at the wrong place, a coding violation or a long silence drops the subframe in progress and clears lock.

The output is a valid/ready stream with a single holding register. When `out_valid` is high and `out_ready` is low, the word and both flags stay unchanged. The register is freed in the same cycle that a transfer takes place. If another subframe finishes while the held word is still waiting, the new subframe is thrown away and the held word is kept. Downstream logic must therefore accept each word within about one subframe time.

Top module: `spdif_subframe_rx`

## Requirements
- R1: While reset is applied and right after it is released, `out_valid` is 0 and `lock_lost` is 1.
- R2: A gap of two half-cells decodes as a 0 and two one-half-cell gaps decode as a 1. The data slot that arrives k-th after the preamble (k = 0..27) appears at `out_data[4+k]`, and `out_data[3:0]` is always 0.
- R3: The half-cell length is taken from the shortest gap measured on the line. No rate is set at build time, so the same block decodes streams whose half-cell lasts 6 clocks or 9 clocks.
- R4: The preamble gap pattern 3-1-1-3 half-cells gives `out_blk_start`=1 and `out_chan_b`=0. The pattern 3-3-1-1 gives both flags 0. The pattern 3-2-1-2 gives `out_chan_b`=1 and `out_blk_start`=0.
- R5: `lock_lost` stays at 1 until two valid preambles in a row have been seen. The first preamble counts from hunting, and the second must follow a complete 28-slot subframe. A subframe is delivered only when lock is held.
- R6: A preamble that arrives before all 28 data slots are in drops the partial subframe and sets `lock_lost` to 1. That preamble counts as the first of a new pair.
- R7: A coding violation drops the current subframe, sets `lock_lost` to 1 and returns the receiver to hunting. Examples are a half-cell gap followed by a full-cell gap, or a gap longer than three and a half half-cells.
- R8: A silence of 2^CNT_W-1 clocks sets `lock_lost` to 1 and clears the stored half-cell length.
- R9: Each complete subframe received under lock produces exactly one transfer on the output.
- R10: While `out_valid`=1 and `out_ready`=0, the output word and flags stay stable. A subframe that completes during that time is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, at least 8 times the cell rate |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Biphase-mark serial line, asynchronous to clk |
| out_valid | output | 1 | Subframe word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Subframe word; data slots in [31:4], [3:0] zero |
| out_chan_b | output | 1 | Word belongs to channel B |
| out_blk_start | output | 1 | Word is the first subframe of a block |
| lock_lost | output | 1 | Receiver is not locked to the stream |

## Verification
If the stored half-cell length goes wrong, the gaps are sorted into the wrong classes. Within one subframe time the receiver then either misses preambles, so `lock_lost` rises and words stop coming, or it delivers words whose data bits are shifted. If the preamble sequencer holds a wrong state, the channel or block flags show up wrong on the very next word. A wrong lock count shows in two ways: either a word appears from the first subframe after hunting, or a word goes missing after the second preamble. A scoreboard in the bench models the lock count and the drop rule for the holding register, so that it catches both extra words and missing ones.

// File: rtl/spdif_rx_pkg.sv
package spdif_rx_pkg;
  localparam int SF_SLOTS   = 32;
  localparam int PRE_SLOTS  = 4;
  localparam int DATA_SLOTS = SF_SLOTS - PRE_SLOTS;

  // gap length class in half-cells
  typedef enum logic [1:0] {
    RUN_SHORT = 2'd0,  // one half-cell
    RUN_LONG  = 2'd1,  // two half-cells
    RUN_XLONG = 2'd2,  // three half-cells (preamble only)
    RUN_BAD   = 2'd3   // out of range or silence
  } run_cls_t;

  typedef enum logic [3:0] {
    PS_HUNT, PS_P1,
    PS_B2, PS_B3, PS_M2, PS_M3, PS_W2, PS_W3,
    PS_D0, PS_D1, PS_WAITP
  } prs_state_t;
endpackage

// File: rtl/spdif_edge_timer.sv
module spdif_edge_timer
  import spdif_rx_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int MIN_PULSE = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     line_in,
  output logic     run_stb,
  output run_cls_t run_cls
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int               XW      = CNT_W + 4;

  logic [2:0]       sync_q;
  logic             edge_seen;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   width, minw_q, eff_m;
  logic             take_min;
  logic [XW-1:0]    w2, m3, m5, m7;
  run_cls_t         cls;

  assign edge_seen = sync_q[2] ^ sync_q[1];
  assign width     = {1'b0, cnt_q} + 1'b1;
  assign take_min  = (width >= (CNT_W+1)'(MIN_PULSE)) && (width < minw_q);
  assign eff_m     = take_min ? width : minw_q;

  always_comb begin
    w2 = XW'(width) << 1;
    m3 = (XW'(eff_m) << 1) + XW'(eff_m);
    m5 = (XW'(eff_m) << 2) + XW'(eff_m);
    m7 = (XW'(eff_m) << 3) - XW'(eff_m);
    if (w2 < m3)      cls = RUN_SHORT;
    else if (w2 < m5) cls = RUN_LONG;
    else if (w2 < m7) cls = RUN_XLONG;
    else              cls = RUN_BAD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      cnt_q   <= '0;
      minw_q  <= {1'b0, CNT_MAX};
      run_stb <= 1'b0;
      run_cls <= RUN_BAD;
    end else begin
      sync_q <= {sync_q[1:0], line_in};
      if (edge_seen) begin
        cnt_q   <= '0;
        run_stb <= 1'b1;
        run_cls <= cls;
        if (take_min) minw_q <= width;
      end else if (cnt_q == CNT_MAX - 1'b1) begin
        cnt_q   <= CNT_MAX;
        run_stb <= 1'b1;
        run_cls <= RUN_BAD;
        minw_q  <= {1'b0, CNT_MAX};
      end else begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        run_stb <= 1'b0;
      end
    end
  end

  AST_SILENCE_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_seen && cnt_q == CNT_MAX - 1'b1) |=> (run_stb && run_cls == RUN_BAD && minw_q == {1'b0, CNT_MAX})); // R8
endmodule

// File: rtl/spdif_bmc_parser.sv
module spdif_bmc_parser
  import spdif_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_stb,
  input  run_cls_t    run_cls,
  output logic        sf_stb,
  output logic [31:0] sf_word,
  output logic        sf_chan_b,
  output logic        sf_blk,
  output logic        locked
);
  localparam int BCW = $clog2(DATA_SLOTS);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_SLOTS - 1);

  prs_state_t          st_q, st_n;
  logic [1:0]          good_q, good_n;
  logic [BCW-1:0]      bitcnt_q;
  logic [DATA_SLOTS-1:0] sh_q;
  logic                chan_b_q, blk_q;
  logic                bit_ev, bit_val, pre_done, pre_b, pre_w;
  logic                restart, violation, fire;

  assign locked = (good_q == 2'd2);

  always_comb begin
    st_n = st_q; good_n = good_q;
    bit_ev = 1'b0; bit_val = 1'b0;
    pre_done = 1'b0; pre_b = 1'b0; pre_w = 1'b0;
    restart = 1'b0; violation = 1'b0;
    if (run_stb) begin
      if (run_cls == RUN_BAD) violation = 1'b1;
      else begin
        unique case (st_q)
          PS_HUNT:  if (run_cls == RUN_XLONG) restart = 1'b1;
          PS_WAITP: if (run_cls == RUN_XLONG) begin
                      st_n   = PS_P1;
                      good_n = (good_q == 2'd2) ? 2'd2 : good_q + 2'd1;
                    end else violation = 1'b1;
          PS_P1:    case (run_cls)
                      RUN_SHORT: st_n = PS_B2;
                      RUN_LONG:  st_n = PS_W2;
                      default:   st_n = PS_M2;
                    endcase
          PS_B2, PS_M2, PS_M3, PS_W2: begin
            if (run_cls == RUN_XLONG) restart = 1'b1;
            else if (run_cls == RUN_LONG) violation = 1'b1;
            else if (st_q == PS_B2) st_n = PS_B3;
            else if (st_q == PS_M2) st_n = PS_M3;
            else if (st_q == PS_W2) st_n = PS_W3;
            else pre_done = 1'b1;
          end
          PS_B3:    if (run_cls == RUN_XLONG) begin pre_done = 1'b1; pre_b = 1'b1; end
                    else violation = 1'b1;
          PS_W3:    if (run_cls == RUN_LONG) begin pre_done = 1'b1; pre_w = 1'b1; end
                    else if (run_cls == RUN_XLONG) restart = 1'b1;
                    else violation = 1'b1;
          PS_D0:    if (run_cls == RUN_LONG) bit_ev = 1'b1;
                    else if (run_cls == RUN_SHORT) st_n = PS_D1;
                    else restart = 1'b1;
          PS_D1:    if (run_cls == RUN_SHORT) begin bit_ev = 1'b1; bit_val = 1'b1; end
                    else if (run_cls == RUN_LONG) violation = 1'b1;
                    else restart = 1'b1;
          default:  violation = 1'b1;
        endcase
      end
      if (pre_done) st_n = PS_D0;
      if (bit_ev) st_n = (bitcnt_q == LAST_BIT) ? PS_WAITP : PS_D0;
      if (restart) begin st_n = PS_P1; good_n = 2'd1; end
      if (violation) begin st_n = PS_HUNT; good_n = 2'd0; end
    end
  end

  assign fire = bit_ev && (bitcnt_q == LAST_BIT) && (good_q == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= PS_HUNT; good_q <= 2'd0; bitcnt_q <= '0; sh_q <= '0;
      chan_b_q <= 1'b0; blk_q <= 1'b0;
      sf_stb <= 1'b0; sf_word <= '0; sf_chan_b <= 1'b0; sf_blk <= 1'b0;
    end else begin
      st_q   <= st_n;
      good_q <= good_n;
      if (pre_done) begin
        bitcnt_q <= '0; chan_b_q <= pre_w; blk_q <= pre_b;
      end
      if (bit_ev) begin
        sh_q     <= {bit_val, sh_q[DATA_SLOTS-1:1]};
        bitcnt_q <= bitcnt_q + 1'b1;
      end
      sf_stb <= fire;
      if (fire) begin
        sf_word   <= {bit_val, sh_q[DATA_SLOTS-1:1], {PRE_SLOTS{1'b0}}};
        sf_chan_b <= chan_b_q;
        sf_blk    <= blk_q;
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    sf_stb |=> !sf_stb); // R9
  AST_BLOCK_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_stb && sf_blk) |-> !sf_chan_b); // R4
  AST_BAD_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_stb && run_cls == RUN_BAD) |=> !locked); // R7
  AST_STROBE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    sf_stb |-> locked); // R5
endmodule

// File: rtl/spdif_out_hold.sv
module spdif_out_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_stb,
  input  logic [W-1:0] in_word,
  input  logic         in_chan_b,
  input  logic         in_blk,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_chan_b,
  output logic         out_blk
);
  logic load;
  assign load = in_stb && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0; out_chan_b <= 1'b0; out_blk <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1; out_data <= in_word;
      out_chan_b <= in_chan_b; out_blk <= in_blk;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan_b) && $stable(out_blk))); // R10
  AST_LOW_SLOTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[3:0] == 4'd0)); // R2
endmodule

// File: rtl/spdif_subframe_rx.sv
module spdif_subframe_rx
  import spdif_rx_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int MIN_PULSE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_in,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_chan_b,
  output logic        out_blk_start,
  output logic        lock_lost
);
  logic        run_stb;
  run_cls_t    run_cls;
  logic        sf_stb, sf_chan_b, sf_blk, locked;
  logic [31:0] sf_word;

  spdif_edge_timer #(.CNT_W(CNT_W), .MIN_PULSE(MIN_PULSE)) u_timer (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .run_stb(run_stb), .run_cls(run_cls));

  spdif_bmc_parser u_parser (
    .clk(clk), .rst_n(rst_n), .run_stb(run_stb), .run_cls(run_cls),
    .sf_stb(sf_stb), .sf_word(sf_word), .sf_chan_b(sf_chan_b),
    .sf_blk(sf_blk), .locked(locked));

  spdif_out_hold #(.W(SF_SLOTS)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_stb(sf_stb), .in_word(sf_word),
    .in_chan_b(sf_chan_b), .in_blk(sf_blk), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data),
    .out_chan_b(out_chan_b), .out_blk(out_blk_start));

  assign lock_lost = !locked;

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && lock_lost)); // R1
endmodule

// File: tb/test_spdif_subframe_rx.sv
module test_spdif_subframe_rx;
  logic        clk = 1'b0, rst_n = 1'b0, line_q = 1'b0, ready = 1'b1;
  logic        out_valid, out_chan_b, out_blk_start, lock_lost;
  logic [31:0] out_data;

  typedef struct { logic [31:0] w; logic cb; logic blk; } exp_t;
  exp_t q[$];
  int n_cmp = 0, n_bad = 0, half = 6, good = 0, mst = 0;
  bit hold_mode = 0, held = 0, done = 0;
  logic [31:0] held_word;

  always #10 clk = ~clk;

  spdif_subframe_rx i_spdif_subframe_rx (
    .clk(clk), .rst_n(rst_n), .line_in(line_q), .out_valid(out_valid),
    .out_ready(ready), .out_data(out_data), .out_chan_b(out_chan_b),
    .out_blk_start(out_blk_start), .lock_lost(lock_lost));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    line_q = ~line_q;
    repeat (n * half) @(negedge clk);
  endtask

  task automatic train();
    repeat (16) run(1);
  endtask

  task automatic quiet();
    repeat (400) @(negedge clk);
    mst = 0; good = 0;
  endtask

  // kind: 0 block-start A, 1 channel A, 2 channel B; rdy: 1 drop ready, 2 raise ready
  task automatic send_sf(input int kind, input logic [27:0] d, input int nbits,
                         input int bad_at, input int rdy);
    exp_t e;
    if (mst != 2) good = (good == 2) ? 2 : good + 1;
    else good = 1;
    mst = 2;
    case (kind)
      0: begin run(3); run(1); run(1); run(3); end
      1: begin run(3); run(3); run(1); run(1); end
      default: begin run(3); run(2); run(1); run(2); end
    endcase
    if (rdy == 1) begin ready = 1'b0; hold_mode = 1; held = 0; end
    if (rdy == 2) begin ready = 1'b1; hold_mode = 0; held = 0; end
    for (int i = 0; i < nbits; i++) begin
      if (i == bad_at) begin run(1); run(2); mst = 0; good = 0; return; end
      if (d[i]) begin run(1); run(1); end
      else run(2);
    end
    if (nbits == 28) begin
      mst = 1;
      if (good == 2 && !(hold_mode && held)) begin
        e.w = {d, 4'b0}; e.cb = (kind == 2); e.blk = (kind == 0);
        q.push_back(e);
        if (hold_mode) begin held = 1; held_word = e.w; end
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && ready) begin
      if (q.size() == 0) chk(0, "R9 unexpected word", out_data, 32'h0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(out_data == e.w, "R2 word", out_data, e.w);
        chk({out_chan_b, out_blk_start} == {e.cb, e.blk}, "R4 flags",
            {30'd0, out_chan_b, out_blk_start}, {30'd0, e.cb, e.blk});
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0 && lock_lost == 1'b1, "R1 reset", {30'd0, out_valid, lock_lost}, 32'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0 && lock_lost == 1'b1, "R1 after release", {30'd0, out_valid, lock_lost}, 32'd1);
    repeat (20) @(negedge clk);
    train();
    send_sf(0, 28'h1234567, 28, -1, 0);
    chk(lock_lost == 1'b1, "R5 one preamble", {31'd0, lock_lost}, 32'd1);
    send_sf(2, 28'hA5C3F01, 28, -1, 0);
    chk(lock_lost == 1'b0, "R5 two preambles", {31'd0, lock_lost}, 32'd0);
    send_sf(1, 28'h0F0F0F0, 28, -1, 0);
    send_sf(2, 28'hFFFFFFF, 28, -1, 0);
    send_sf(1, 28'h0000000, 28, -1, 0);
    send_sf(2, 28'h5555555, 28, -1, 0);
    // R6: truncated subframe, early preamble
    send_sf(1, 28'h3333333, 10, -1, 0);
    send_sf(2, 28'h7654321, 28, -1, 0);
    chk(lock_lost == 1'b1, "R6 early preamble", {31'd0, lock_lost}, 32'd1);
    send_sf(0, 28'h8888888, 28, -1, 0);
    chk(lock_lost == 1'b0, "R6 relock", {31'd0, lock_lost}, 32'd0);
    // R7: coding violation
    send_sf(2, 28'hFFFFFFF, 28, 5, 0);
    send_sf(1, 28'h1111111, 28, -1, 0);
    chk(lock_lost == 1'b1, "R7 violation", {31'd0, lock_lost}, 32'd1);
    send_sf(2, 28'h2468ACE, 28, -1, 0);
    // R10: back-pressure
    send_sf(1, 28'h9ABCDEF, 28, -1, 1);
    send_sf(2, 28'hCAFE123, 28, -1, 0);
    chk(out_valid == 1'b1 && out_data == held_word, "R10 held word", out_data, held_word);
    send_sf(1, 28'h0123ABC, 28, -1, 2);
    run(1);
    quiet();
    chk(lock_lost == 1'b1, "R8 silence", {31'd0, lock_lost}, 32'd1);
    chk(q.size() == 0, "R9 all delivered", q.size(), 32'd0);
    // R3: slower rate after silence
    half = 9;
    train();
    send_sf(0, 28'hBEEF123, 28, -1, 0);
    send_sf(2, 28'h6DB6DB6, 28, -1, 0);
    send_sf(1, 28'h4924924, 28, -1, 0);
    run(1);
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R3 slow rate delivered", q.size(), 32'd0);
    quiet();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule